// File: doc/BRIEF.md
# Dual-Path Latched/Registered Bus Transceiver

This block connects two 18-bit three-state buses, called A and B. Each direction has its own storage cell, its own latch enable, its own clock and its own output enable. Data is never inverted. While a direction's latch enable is high, its cell is transparent and the far bus follows the near bus. While the latch enable is low, the cell keeps its value until a falling clock edge loads the near bus value.

The A-to-B output enable is active high. The B-to-A output enable is active low. This means that tying both enables to the same level leaves only one direction driving. A separate flag reports when both directions are enabled at the same time, which would make the two buses fight. The buses are plain level-driven wires with no handshake, so there is no valid/ready pairing and no back-pressure. Any value on a bus is taken as data.

Top module: `bus_xcvr`

## Requirements
- R1: Each path is 18 bits wide and carries every bit unchanged (non-inverting). This is checked with alternating and with sparse bit patterns.
- R2: While `ab_le` is 1, the A-to-B cell is transparent, so `b_io` equals `a_io` whenever `ab_oe` is 1.
- R3: While `ab_le` is 0 and `ab_clk` does not fall, the A-to-B cell holds its value. When `ab_le` falls with the clock steady, the cell keeps the `a_io` value present just before the fall.
- R4: While `ab_le` is 0, a 1-to-0 transition of `ab_clk` loads `a_io` into the A-to-B cell. A 0-to-1 transition loads nothing.
- R5: With `ab_oe` = 1 the block drives `b_io` from the A-to-B cell. With `ab_oe` = 0 it leaves `b_io` undriven, so another driver's value reads back unchanged.
- R6: The B-to-A path behaves as R2 to R4 with `b_io` as its input, `ba_le` as its latch enable and `ba_clk` as its clock.
- R7: With `ba_oe_n` = 0 the block drives `a_io` from the B-to-A cell. With `ba_oe_n` = 1 it leaves `a_io` undriven.
- R8: The two cells are independent. A load or a bus change on one path never alters the value stored by the other path.
- R9: A falling clock edge while the latch enable is 1 changes nothing, and the cell keeps following its input.
- R10: `drive_clash` is 1 exactly when `ab_oe` is 1 and `ba_oe_n` is 0 together. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_io | inout | 18 | A bus: input to the A-to-B path, driven by the B-to-A path |
| b_io | inout | 18 | B bus: input to the B-to-A path, driven by the A-to-B path |
| ab_le | input | 1 | A-to-B latch enable, transparent when 1 |
| ab_clk | input | 1 | A-to-B clock, loads on the falling edge while `ab_le` is 0 |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A latch enable, transparent when 1 |
| ba_clk | input | 1 | B-to-A clock, loads on the falling edge while `ba_le` is 0 |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| drive_clash | output | 1 | Both directions enabled at once |

## Verification
Every result is combinational from the control and bus inputs. A transparent update, a falling-edge load, an enable change and the clash flag all show up in the same time step as the stimulus that causes them, with no register delay between pin and pin. The bench changes every input, including the transceiver clocks, just after a bench clock rising edge and queues the expected bus and flag values. The monitor compares them half a period later, on the falling edge, when everything has settled. Loads are placed in a step of their own, separate from the data change they must capture or ignore, so that no result depends on ordering within one time step.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_DEF_W = 18;

  typedef enum logic {
    OE_HIGH_ACTIVE = 1'b0,
    OE_LOW_ACTIVE  = 1'b1
  } oe_pol_e;
endpackage

// File: rtl/xcvr_cell.sv
module xcvr_cell #(
  parameter int unsigned W = 18
) (
  input  logic [W-1:0] d,
  input  logic         le,
  input  logic         clk,
  output logic [W-1:0] q
);
  logic [W-1:0] lat_q;
  logic [W-1:0] edge_q;
  logic         use_edge;

  // Latch half: tracks d while enabled, freezes on the enable's fall.
  always_latch begin
    if (le) lat_q <= d;
  end

  // Edge half: samples d on every falling clock edge.
  always_ff @(negedge clk) begin
    edge_q <= d;
  end

  // Selects the edge half once a falling edge occurs with le low;
  // a rise of le hands control back to the latch half.
  always_ff @(negedge clk or posedge le) begin
    if (le) use_edge <= 1'b0;
    else    use_edge <= 1'b1;
  end

  assign q = le ? d : (use_edge ? edge_q : lat_q);
endmodule

// File: rtl/xcvr_tsdrv.sv
module xcvr_tsdrv #(
  parameter int unsigned W = 18
) (
  input  logic [W-1:0] d,
  input  logic         en,
  inout  wire  [W-1:0] y
);
  assign y = en ? d : {W{1'bz}};
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int unsigned W      = 18,
  parameter oe_pol_e     OE_POL = OE_HIGH_ACTIVE
) (
  input  wire  [W-1:0] src,
  inout  wire  [W-1:0] dst,
  input  logic         le,
  input  logic         clk,
  input  logic         oe,
  output logic [W-1:0] q,
  output logic         drv_en
);
  generate
    if (OE_POL == OE_LOW_ACTIVE) begin : g_oe_low
      assign drv_en = ~oe;
    end else begin : g_oe_high
      assign drv_en = oe;
    end
  endgenerate

  xcvr_cell #(.W(W)) u_cell (
    .d   (src),
    .le  (le),
    .clk (clk),
    .q   (q)
  );

  xcvr_tsdrv #(.W(W)) u_drv (
    .d  (q),
    .en (drv_en),
    .y  (dst)
  );
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_DEF_W
) (
  inout  wire  [W-1:0] a_io,
  inout  wire  [W-1:0] b_io,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ab_oe,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic         ba_oe_n,
  output logic         drive_clash
);
  logic [W-1:0] ab_q;
  logic [W-1:0] ba_q;
  logic         ab_en;
  logic         ba_en;

  xcvr_lane #(.W(W), .OE_POL(OE_HIGH_ACTIVE)) u_ab (
    .src    (a_io),
    .dst    (b_io),
    .le     (ab_le),
    .clk    (ab_clk),
    .oe     (ab_oe),
    .q      (ab_q),
    .drv_en (ab_en)
  );

  xcvr_lane #(.W(W), .OE_POL(OE_LOW_ACTIVE)) u_ba (
    .src    (b_io),
    .dst    (a_io),
    .le     (ba_le),
    .clk    (ba_clk),
    .oe     (ba_oe_n),
    .q      (ba_q),
    .drv_en (ba_en)
  );

  assign drive_clash = ab_en & ba_en;
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int unsigned W = 18
) (
  input wire  [W-1:0] a_io,
  input wire  [W-1:0] b_io,
  input logic         ab_le,
  input logic         ab_clk,
  input logic         ab_oe,
  input logic         ba_le,
  input logic         ba_clk,
  input logic         ba_oe_n,
  input logic         drive_clash,
  input logic [W-1:0] ab_q,
  input logic [W-1:0] ba_q
);
  AST_AB_TRANSPARENT: assert property (@(negedge ab_clk) ab_le |-> (ab_q == a_io)); // R2
  AST_B_DRIVEN:       assert property (@(negedge ab_clk) ab_oe |-> (b_io == ab_q)); // R5
  AST_BA_TRANSPARENT: assert property (@(negedge ba_clk) ba_le |-> (ba_q == b_io)); // R6
  AST_A_DRIVEN:       assert property (@(negedge ba_clk) !ba_oe_n |-> (a_io == ba_q)); // R7
  AST_CLASH_FLAG:     assert property (@(negedge ab_clk) (ab_oe && !ba_oe_n) |-> drive_clash); // R10
endmodule

bind bus_xcvr xcvr_chk #(.W(W)) u_chk (
  .a_io        (a_io),
  .b_io        (b_io),
  .ab_le       (ab_le),
  .ab_clk      (ab_clk),
  .ab_oe       (ab_oe),
  .ba_le       (ba_le),
  .ba_clk      (ba_clk),
  .ba_oe_n     (ba_oe_n),
  .drive_clash (drive_clash),
  .ab_q        (ab_q),
  .ba_q        (ba_q)
);

// File: tb/test_bus_xcvr.sv
`timescale 1ns/1ps
module test_bus_xcvr;
  localparam int W = 18;

  typedef struct {
    bit           ca;
    logic [W-1:0] ea;
    bit           cb;
    logic [W-1:0] eb;
    logic         clash;
    string        tag;
  } item_t;

  item_t sb[$];
  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 0;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         ab_le = 1'b0, ab_clk = 1'b1, ab_oe = 1'b0;
  logic         ba_le = 1'b0, ba_clk = 1'b1, ba_oe_n = 1'b1;
  logic         a_en = 1'b1, b_en = 1'b1;
  logic [W-1:0] a_val = 18'h3C0F3;
  logic [W-1:0] b_val = 18'h0A5A5;
  wire  [W-1:0] a_io, b_io;
  logic         drive_clash;

  assign a_io = a_en ? a_val : {W{1'bz}};
  assign b_io = b_en ? b_val : {W{1'bz}};

  bus_xcvr #(.W(W)) i_bus_xcvr (
    .a_io(a_io), .b_io(b_io),
    .ab_le(ab_le), .ab_clk(ab_clk), .ab_oe(ab_oe),
    .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n),
    .drive_clash(drive_clash)
  );

  // Driver side: queue what the requirements predict for this step.
  task automatic push(input bit ca, input logic [W-1:0] ea,
                      input bit cb, input logic [W-1:0] eb, input string tag);
    item_t it;
    it.ca = ca; it.ea = ea; it.cb = cb; it.eb = eb; it.tag = tag;
    it.clash = ab_oe & ~ba_oe_n; // R10
    sb.push_back(it);
  endtask

  // Monitor: compare half a period after each stimulus.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      if (it.ca) begin
        n_chk++;
        if (a_io !== it.ea) begin
          n_err++;
          $display("FAIL %s a_io: got %h expected %h", it.tag, a_io, it.ea);
        end
      end
      if (it.cb) begin
        n_chk++;
        if (b_io !== it.eb) begin
          n_err++;
          $display("FAIL %s b_io: got %h expected %h", it.tag, b_io, it.eb);
        end
      end
      n_chk++;
      if (drive_clash !== it.clash) begin
        n_err++;
        $display("FAIL R10 (%s) drive_clash: got %b expected %b", it.tag, drive_clash, it.clash);
      end
    end
  end

  initial begin
    @(posedge clk); push(1, 18'h3C0F3, 1, 18'h0A5A5, "R5 R7 idle undriven");
    // A-to-B transparency
    @(posedge clk); ab_le = 1; b_en = 0; ab_oe = 1; a_val = 18'h2AAAA;
    push(1, 18'h2AAAA, 1, 18'h2AAAA, "R2");
    @(posedge clk); a_val = 18'h15555; push(0, '0, 1, 18'h15555, "R1");
    @(posedge clk); ab_clk = 0; a_val = 18'h3FFFF; push(0, '0, 1, 18'h3FFFF, "R9");
    @(posedge clk); ab_clk = 1; a_val = 18'h00001; push(0, '0, 1, 18'h00001, "R9");
    // hold after enable fall
    @(posedge clk); ab_le = 0; push(0, '0, 1, 18'h00001, "R3");
    @(posedge clk); a_val = 18'h12345; push(0, '0, 1, 18'h00001, "R3");
    // falling-edge load, rising edge ignored
    @(posedge clk); ab_clk = 0; push(0, '0, 1, 18'h12345, "R4");
    @(posedge clk); a_val = 18'h2F0F0; ab_clk = 1; push(0, '0, 1, 18'h12345, "R4");
    @(posedge clk); ab_clk = 0; push(0, '0, 1, 18'h2F0F0, "R4");
    @(posedge clk); a_val = 18'h11111; push(0, '0, 1, 18'h2F0F0, "R3");
    // B undriven when disabled
    @(posedge clk); ab_oe = 0; b_en = 1; b_val = 18'h0BEEF;
    push(1, 18'h11111, 1, 18'h0BEEF, "R5");
    // B-to-A path
    @(posedge clk); a_en = 0; ba_oe_n = 0; ba_le = 1; b_val = 18'h1CAFE;
    push(1, 18'h1CAFE, 1, 18'h1CAFE, "R6");
    @(posedge clk); ba_le = 0; push(1, 18'h1CAFE, 0, '0, "R6");
    @(posedge clk); b_val = 18'h2DEAD; push(1, 18'h1CAFE, 0, '0, "R6");
    @(posedge clk); ba_clk = 0; push(1, 18'h2DEAD, 0, '0, "R6");
    @(posedge clk); ba_clk = 1; b_val = 18'h30303; push(1, 18'h2DEAD, 0, '0, "R6");
    // A undriven when disabled
    @(posedge clk); ba_oe_n = 1; a_en = 1; a_val = 18'h04444; push(1, 18'h04444, 0, '0, "R7");
    // independence of the two stores
    @(posedge clk); b_en = 0; ab_oe = 1; push(0, '0, 1, 18'h2F0F0, "R8");
    @(posedge clk); ab_oe = 0; b_en = 1; b_val = 18'h15A5A; a_en = 0; ba_oe_n = 0;
    push(1, 18'h2DEAD, 1, 18'h15A5A, "R8");
    // both directions enabled
    @(posedge clk); b_en = 0; ab_oe = 1; push(1, 18'h2DEAD, 1, 18'h2F0F0, "R10");
    @(posedge clk); ab_oe = 0; b_en = 1; b_val = 18'h00000; push(1, 18'h2DEAD, 1, 18'h00000, "R10");
    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule